// File: doc/BRIEF.md
# Receive Frame Buffer with Overrun Flagging

This block holds received CAN and CAN FD frames until the host reads them. The protocol engine delivers each frame as a descriptor word followed by its payload words, and then commits or abandons it. The buffer stores every frame as one block of consecutive 32-bit words in this order: the descriptor, a 64-bit receive timestamp split into a low word and a high word, and then the payload. A reader that fetches the descriptor first can therefore work out how many words follow before it reads them.

Space is checked once, when the descriptor arrives, against the full length of the frame. A frame that does not fit is dropped as a whole. Dropping a frame sets a sticky overrun status and raises an overrun interrupt flag, and each of the two has its own clear command. The read port pops one word per access. A not-empty output tells the host that at least one complete frame is waiting. The timestamp is taken from an external time base, either at the end-of-frame commit or at the start-of-frame pulse, as a configuration input selects.

Top module: `rxframe_fifo`

## Requirements
- R1: A stored frame reads back as: descriptor, timestamp bits 31:0, timestamp bits 63:32, then the payload words in arrival order. The descriptor carries the length code in bits 3:0 and the FD type in bit 5.
- R2: `rx_nempty` is high exactly when one or more committed frames are unread. It stays low while a frame is still being written and goes high in the cycle after `in_eof`.
- R3: A read with `rd_en` pops one word. While the buffer is empty, `rd_data` is zero and a read moves nothing.
- R4: A frame is stored only if 3 plus its payload word count is no larger than the free words at its descriptor cycle, so a frame that fills the buffer exactly is accepted. A frame that does not fit is dropped, and its payload words and `in_eof` are ignored.
- R5: `ovr_sts` is set in the cycle after a dropped descriptor. It stays set until a `cmd_clr_ovr` pulse, and it is low in the cycle after that pulse.
- R6: `ovr_irq` is set together with `ovr_sts`. It is low in the cycle after any `cmd_clr_irq` pulse, even when a set request arrives in the same cycle.
- R7: While `ovr_sts` remains set, `ovr_irq` is set again one cycle after it has been cleared.
- R8: With `cfg_ts_sof` low, the stored timestamp is the value of `ts_base` in the `in_eof` cycle. With `cfg_ts_sof` high, it is the value of `ts_base` at the most recent `in_sof` pulse.
- R9: `in_abort` discards the frame being written. It never becomes readable, and the space it had reserved is free again at once.
- R10: The payload word count is ceil(bytes/4). Classic frames (bit 5 = 0) carry min(code,8) bytes. FD frames carry 0 to 8 bytes for codes 0 to 8, and 12, 16, 20, 24, 32, 48 or 64 bytes for codes 9 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ts_sof | input | 1 | 1: timestamp taken at start of frame; 0: taken at commit |
| ts_base | input | 64 | External time base |
| in_sof | input | 1 | Start-of-frame pulse from the protocol engine |
| in_hdr_vld | input | 1 | Descriptor valid; starts a frame |
| in_hdr | input | 32 | Descriptor word |
| in_word_vld | input | 1 | Payload word valid |
| in_word | input | 32 | Payload word |
| in_eof | input | 1 | Commits the frame being written |
| in_abort | input | 1 | Abandons the frame being written |
| rd_en | input | 1 | Pops one word |
| rd_data | output | 32 | Word at the read position, zero when empty |
| rx_nempty | output | 1 | At least one complete frame stored |
| ovr_sts | output | 1 | Sticky overrun status |
| ovr_irq | output | 1 | Overrun interrupt flag |
| cmd_clr_ovr | input | 1 | Clears the overrun status |
| cmd_clr_irq | input | 1 | Clears the overrun interrupt flag |

## Verification
The interrupt flag has two sources that can act in the same cycle: the set request from a dropped frame, or from a still-set overrun status, and the host clear command. The bench fills the buffer and then asserts `cmd_clr_irq` in the same cycle as the descriptor of a frame that cannot fit. It expects the flag to be low one cycle later and high again the cycle after that, because the status is still set. It then clears status and flag together and expects both to stay low.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int WORD_W    = 32;
  localparam int TS_W      = 64;
  localparam int HDR_WORDS = 3;   // descriptor + two timestamp words
  localparam int DW_W      = 5;   // payload word count, up to 16
  localparam int CODE_LSB  = 0;   // length code field [3:0]
  localparam int FD_BIT    = 5;   // frame type bit

  // payload words for a length code; classic codes above 8 saturate
  function automatic logic [DW_W-1:0] payload_words(input logic fd, input logic [3:0] code);
    logic [DW_W-1:0] n;
    if (!fd) begin
      n = (code == 4'd0) ? 5'd0 : (code <= 4'd4) ? 5'd1 : 5'd2;
    end else begin
      case (code)
        4'd0:                   n = 5'd0;
        4'd1, 4'd2, 4'd3, 4'd4: n = 5'd1;
        4'd5, 4'd6, 4'd7, 4'd8: n = 5'd2;
        4'd9:                   n = 5'd3;
        4'd10:                  n = 5'd4;
        4'd11:                  n = 5'd5;
        4'd12:                  n = 5'd6;
        4'd13:                  n = 5'd8;
        4'd14:                  n = 5'd12;
        default:                n = 5'd16;
      endcase
    end
    return n;
  endfunction
endpackage

// File: rtl/rxf_tstamp.sv
module rxf_tstamp
  import rxf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_sof,
  input  logic            sof,
  input  logic [TS_W-1:0] ts_base,
  output logic [TS_W-1:0] stamp
);
  logic [TS_W-1:0] held_q, held_d;
  logic            cap_en;

  always_comb begin
    cap_en = cfg_sof & sof;
    held_d = cap_en ? ts_base : held_q;
    stamp  = cfg_sof ? held_q : ts_base;   // commit mode samples live value
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end
endmodule

// File: rtl/rxf_ovr_flags.sv
module rxf_ovr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovr_evt,
  input  logic clr_sts,
  input  logic clr_irq,
  output logic sts_q,
  output logic irq_q
);
  logic sts_d, irq_d;

  always_comb begin
    sts_d = ovr_evt ? 1'b1 : (clr_sts ? 1'b0 : sts_q);
    // clear has priority over both set sources
    if (clr_irq)                irq_d = 1'b0;
    else if (ovr_evt || sts_q)  irq_d = 1'b1;
    else                        irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_vld,
  input  logic [WORD_W-1:0] hdr,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  input  logic              eof,
  input  logic              abort,
  input  logic [TS_W-1:0]   stamp,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              nempty,
  output logic              ovr_evt
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     cmt_q, cmt_d, rd_q, rd_d, used, free_w;
  logic              act_q, act_d;
  logic [DW_W-1:0]   len_q, len_d, idx_q, idx_d, hdr_dw;
  logic              fits, start, data_we, commit, drop, pop;
  logic [AW-1:0]     base, a_dat, a_ts0, a_ts1;

  always_comb begin
    hdr_dw  = payload_words(hdr[FD_BIT], hdr[CODE_LSB +: 4]);
    used    = cmt_q - rd_q;
    free_w  = PW'(DEPTH) - used;
    fits    = (32'(hdr_dw) + 32'(HDR_WORDS)) <= 32'(free_w);
    start   = hdr_vld & fits;
    ovr_evt = hdr_vld & ~fits;
    data_we = word_vld & act_q & ~hdr_vld & (idx_q < len_q);
    drop    = abort & act_q & ~hdr_vld;
    commit  = eof & act_q & ~hdr_vld & ~abort;
    nempty  = (cmt_q != rd_q);
    pop     = rd_en & nempty;

    // the frame base is always the commit pointer: abandoning needs no rewind
    base  = cmt_q[AW-1:0];
    a_ts0 = base + AW'(1);
    a_ts1 = base + AW'(2);
    a_dat = base + AW'(HDR_WORDS) + AW'(idx_q);

    act_d = act_q;
    len_d = len_q;
    idx_d = idx_q;
    cmt_d = cmt_q;
    if (hdr_vld) begin
      act_d = fits;
      len_d = hdr_dw;
      idx_d = '0;
    end else begin
      if (data_we)        idx_d = idx_q + DW_W'(1);
      if (drop || commit) act_d = 1'b0;
      if (commit)         cmt_d = cmt_q + PW'(HDR_WORDS) + PW'(len_q);
    end
    rd_d = pop ? rd_q + PW'(1) : rd_q;

    rd_data = nempty ? mem_q[rd_q[AW-1:0]] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmt_q <= '0;
      rd_q  <= '0;
      act_q <= 1'b0;
      len_q <= '0;
      idx_q <= '0;
    end else begin
      cmt_q <= cmt_d;
      rd_q  <= rd_d;
      act_q <= act_d;
      len_q <= len_d;
      idx_q <= idx_d;
    end
  end

  // storage array: no reset, written only through explicit enables
  always_ff @(posedge clk) begin
    if (start)   mem_q[base]  <= hdr;
    if (data_we) mem_q[a_dat] <= word;
    if (commit) begin
      mem_q[a_ts0] <= stamp[31:0];
      mem_q[a_ts1] <= stamp[63:32];
    end
  end
endmodule

// File: rtl/rxframe_fifo.sv
module rxframe_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ts_sof,
  input  logic [TS_W-1:0]   ts_base,
  input  logic              in_sof,
  input  logic              in_hdr_vld,
  input  logic [WORD_W-1:0] in_hdr,
  input  logic              in_word_vld,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_eof,
  input  logic              in_abort,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rx_nempty,
  output logic              ovr_sts,
  output logic              ovr_irq,
  input  logic              cmd_clr_ovr,
  input  logic              cmd_clr_irq
);
  logic [1:0]      rsync_q;
  logic            rst_i_n;
  logic [TS_W-1:0] stamp;
  logic            ovr_evt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  rxf_tstamp u_ts (
    .clk(clk), .rst_n(rst_i_n), .cfg_sof(cfg_ts_sof), .sof(in_sof),
    .ts_base(ts_base), .stamp(stamp)
  );

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_i_n), .hdr_vld(in_hdr_vld), .hdr(in_hdr),
    .word_vld(in_word_vld), .word(in_word), .eof(in_eof), .abort(in_abort),
    .stamp(stamp), .rd_en(rd_en), .rd_data(rd_data), .nempty(rx_nempty),
    .ovr_evt(ovr_evt)
  );

  rxf_ovr_flags u_flags (
    .clk(clk), .rst_n(rst_i_n), .ovr_evt(ovr_evt), .clr_sts(cmd_clr_ovr),
    .clr_irq(cmd_clr_irq), .sts_q(ovr_sts), .irq_q(ovr_irq)
  );
endmodule

// File: rtl/rxframe_fifo_chk.sv
module rxframe_fifo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_hdr_vld,
  input logic        in_eof,
  input logic        rd_en,
  input logic [31:0] rd_data,
  input logic        rx_nempty,
  input logic        ovr_sts,
  input logic        ovr_irq,
  input logic        cmd_clr_ovr,
  input logic        cmd_clr_irq
);
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_nempty |-> rd_data == 32'd0);                                  // R3
  AST_NO_EARLY_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_nempty && !in_eof |=> !rx_nempty);                             // R2
  AST_NEMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_nempty && !rd_en |=> rx_nempty);                                // R2
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_sts && !cmd_clr_ovr |=> ovr_sts);                              // R5
  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr_ovr && !in_hdr_vld |=> !ovr_sts);                          // R5
  AST_IRQ_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr_irq |=> !ovr_irq);                                         // R6
  AST_IRQ_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_sts && !cmd_clr_irq |=> ovr_irq);                              // R7
endmodule

bind rxframe_fifo rxframe_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_hdr_vld(in_hdr_vld), .in_eof(in_eof),
  .rd_en(rd_en), .rd_data(rd_data), .rx_nempty(rx_nempty),
  .ovr_sts(ovr_sts), .ovr_irq(ovr_irq), .cmd_clr_ovr(cmd_clr_ovr),
  .cmd_clr_irq(cmd_clr_irq)
);

// File: tb/rxframe_fifo_tb.sv
`timescale 1ns/1ps
module rxframe_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_ts_sof;
  logic [63:0] ts_base;
  logic        in_sof, in_hdr_vld, in_word_vld, in_eof, in_abort, rd_en;
  logic [31:0] in_hdr, in_word, rd_data;
  logic        rx_nempty, ovr_sts, ovr_irq, cmd_clr_ovr, cmd_clr_irq;

  int ntests = 0;
  int nfail  = 0;
  logic nempty_mid, ovr_mid, irq_mid, irq_mid2;

  always #4 clk = ~clk;  // 125 MHz

  rxframe_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ts_sof(cfg_ts_sof), .ts_base(ts_base),
    .in_sof(in_sof), .in_hdr_vld(in_hdr_vld), .in_hdr(in_hdr),
    .in_word_vld(in_word_vld), .in_word(in_word), .in_eof(in_eof),
    .in_abort(in_abort), .rd_en(rd_en), .rd_data(rd_data),
    .rx_nempty(rx_nempty), .ovr_sts(ovr_sts), .ovr_irq(ovr_irq),
    .cmd_clr_ovr(cmd_clr_ovr), .cmd_clr_irq(cmd_clr_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic fd, input logic [3:0] code);
    if (!fd) return (code > 4'd8) ? 8 : int'(code);
    if (code <= 4'd8) return int'(code);
    case (code)
      4'd9:  return 12;
      4'd10: return 16;
      4'd11: return 20;
      4'd12: return 24;
      4'd13: return 32;
      4'd14: return 48;
      default: return 64;
    endcase
  endfunction

  function automatic int nwords(input logic fd, input logic [3:0] code);
    return (nbytes(fd, code) + 3) / 4;
  endfunction

  function automatic logic [31:0] mk_hdr(input logic fd, input logic [3:0] code, input logic [15:0] tag);
    return {tag, 8'h00, 2'b00, fd, 1'b0, code};
  endfunction

  task automatic push(input logic fd, input logic [3:0] code, input logic [15:0] tag,
                      input logic [63:0] sofv, input logic [63:0] eofv,
                      input bit do_abort, input bit clr_at_hdr);
    int n;
    n = nwords(fd, code);
    @(negedge clk);
    in_sof = 1'b1; ts_base = sofv;
    @(negedge clk);
    in_sof = 1'b0; ts_base = 64'd0;
    in_hdr_vld = 1'b1; in_hdr = mk_hdr(fd, code, tag); cmd_clr_irq = clr_at_hdr;
    @(negedge clk);
    in_hdr_vld = 1'b0; cmd_clr_irq = 1'b0;
    nempty_mid = rx_nempty; ovr_mid = ovr_sts; irq_mid = ovr_irq; irq_mid2 = ovr_irq;
    for (int i = 0; i < n; i++) begin
      in_word_vld = 1'b1; in_word = {tag, 16'(i)};
      @(negedge clk);
      if (i == 0) irq_mid2 = ovr_irq;
    end
    in_word_vld = 1'b0;
    ts_base = eofv;
    if (do_abort) in_abort = 1'b1; else in_eof = 1'b1;
    @(negedge clk);
    in_abort = 1'b0; in_eof = 1'b0; ts_base = 64'd0;
  endtask

  task automatic read_frame(input logic fd, input logic [3:0] code, input logic [15:0] tag,
                            input logic [63:0] ts, input string req);
    int n;
    logic [31:0] exp;
    n = nwords(fd, code);
    for (int i = 0; i < n + 3; i++) begin
      if (i == 0)      exp = mk_hdr(fd, code, tag);
      else if (i == 1) exp = ts[31:0];
      else if (i == 2) exp = ts[63:32];
      else             exp = {tag, 16'(i - 3)};
      chk(req, 64'(rd_data), 64'(exp));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
  endtask

  task automatic pulse_clr(input bit c_ovr, input bit c_irq);
    cmd_clr_ovr = c_ovr; cmd_clr_irq = c_irq;
    @(negedge clk);
    cmd_clr_ovr = 1'b0; cmd_clr_irq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    ntests++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    logic [63:0] sv, ev;
    logic [15:0] tg;
    rst_n = 1'b0; cfg_ts_sof = 1'b0; ts_base = '0;
    in_sof = 0; in_hdr_vld = 0; in_hdr = '0; in_word_vld = 0; in_word = '0;
    in_eof = 0; in_abort = 0; rd_en = 0; cmd_clr_ovr = 0; cmd_clr_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R2 reset nempty", 64'(rx_nempty), 64'd0);
    chk("R5 reset ovr_sts", 64'(ovr_sts), 64'd0);
    chk("R6 reset ovr_irq", 64'(ovr_irq), 64'd0);

    // R3: read while empty returns zero and moves nothing
    chk("R3 empty data", 64'(rd_data), 64'd0);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk("R3 empty data after read", 64'(rd_data), 64'd0);
    push(1'b0, 4'd3, 16'h0F0F, 64'd1, 64'h0000_0002_0000_0003, 1'b0, 1'b0);
    read_frame(1'b0, 4'd3, 16'h0F0F, 64'h0000_0002_0000_0003, "R3 no pointer slip");

    // R1 R8 R10: every length code, both types, both timestamp modes
    for (int m = 0; m < 2; m++) begin
      @(negedge clk); cfg_ts_sof = m[0];
      for (int f = 0; f < 2; f++) begin
        for (int c = 0; c < 16; c++) begin
          tg = 16'(m * 32 + f * 16 + c + 1);
          sv = {32'h5000_0000 + 32'(tg), 32'hA000_0000 + 32'(tg)};
          ev = {32'hC000_0000 + 32'(tg), 32'h0000_3000 + 32'(tg)};
          push(f[0], c[3:0], tg, sv, ev, 1'b0, 1'b0);
          chk("R2 hidden before eof", 64'(nempty_mid), 64'd0);
          chk("R2 visible after eof", 64'(rx_nempty), 64'd1);
          read_frame(f[0], c[3:0], tg, m[0] ? sv : ev, "R1 R8 R10 frame words");
          chk("R3 drained", 64'(rx_nempty), 64'd0);
        end
      end
    end
    @(negedge clk); cfg_ts_sof = 1'b0;

    // R4: exact fill accepted, one more frame dropped
    push(1'b1, 4'd14, 16'h0100, 64'd0, 64'h11, 1'b0, 1'b0);   // 15 words
    push(1'b1, 4'd13, 16'h0101, 64'd0, 64'h12, 1'b0, 1'b0);   // 11 words
    push(1'b1, 4'd9,  16'h0102, 64'd0, 64'h13, 1'b0, 1'b0);   // 6 words: exact fit
    chk("R4 exact fit no overrun", 64'(ovr_sts), 64'd0);
    push(1'b0, 4'd8,  16'h0103, 64'd0, 64'h14, 1'b0, 1'b0);   // 5 words: no room
    chk("R4 R5 ovr_sts after drop", 64'(ovr_mid), 64'd1);
    chk("R6 ovr_irq after drop", 64'(irq_mid), 64'd1);
    read_frame(1'b1, 4'd14, 16'h0100, 64'h11, "R4 frame A");
    read_frame(1'b1, 4'd13, 16'h0101, 64'h12, "R4 frame B");
    read_frame(1'b1, 4'd9,  16'h0102, 64'h13, "R4 frame C");
    chk("R4 dropped frame absent", 64'(rx_nempty), 64'd0);
    chk("R4 dropped frame data", 64'(rd_data), 64'd0);
    chk("R5 status sticky", 64'(ovr_sts), 64'd1);

    // R6 R7: clear irq alone while status set
    pulse_clr(1'b0, 1'b1);
    chk("R6 irq cleared", 64'(ovr_irq), 64'd0);
    @(negedge clk);
    chk("R7 irq rearmed", 64'(ovr_irq), 64'd1);
    chk("R5 status unaffected", 64'(ovr_sts), 64'd1);
    // R5: status clear, then irq clear stays clear
    pulse_clr(1'b1, 1'b0);
    chk("R5 status cleared", 64'(ovr_sts), 64'd0);
    chk("R6 irq held", 64'(ovr_irq), 64'd1);
    pulse_clr(1'b0, 1'b1);
    chk("R6 irq cleared after status", 64'(ovr_irq), 64'd0);
    @(negedge clk);
    chk("R7 no rearm without status", 64'(ovr_irq), 64'd0);

    // R6: clear and set in the same cycle
    push(1'b1, 4'd15, 16'h0200, 64'd0, 64'h21, 1'b0, 1'b0);   // 19 words
    push(1'b1, 4'd14, 16'h0201, 64'd0, 64'h22, 1'b0, 1'b1);   // 15 words, dropped
    chk("R5 same-cycle status set", 64'(ovr_mid), 64'd1);
    chk("R6 clear beats set", 64'(irq_mid), 64'd0);
    chk("R7 rearm after clear", 64'(irq_mid2), 64'd1);
    pulse_clr(1'b1, 1'b1);
    chk("R5 both cleared sts", 64'(ovr_sts), 64'd0);
    chk("R6 both cleared irq", 64'(ovr_irq), 64'd0);
    @(negedge clk);
    chk("R7 stays clear", 64'(ovr_irq), 64'd0);
    read_frame(1'b1, 4'd15, 16'h0200, 64'h21, "R4 survivor");
    chk("R4 drained", 64'(rx_nempty), 64'd0);

    // R9: abandoned frame invisible, its space returned
    push(1'b1, 4'd15, 16'h0300, 64'd0, 64'h31, 1'b1, 1'b0);
    chk("R9 hidden during write", 64'(nempty_mid), 64'd0);
    chk("R9 not visible after abort", 64'(rx_nempty), 64'd0);
    push(1'b1, 4'd15, 16'h0301, 64'd0, 64'h32, 1'b0, 1'b0);   // 19
    push(1'b1, 4'd13, 16'h0302, 64'd0, 64'h33, 1'b0, 1'b0);   // 11, fits only if space returned
    chk("R9 no overrun after abort", 64'(ovr_sts), 64'd0);
    read_frame(1'b1, 4'd15, 16'h0301, 64'h32, "R9 next frame");
    read_frame(1'b1, 4'd13, 16'h0302, 64'h33, "R9 second frame");
    chk("R9 drained", 64'(rx_nempty), 64'd0);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule